// File: doc/BRIEF.md
# Dual Word FIFO with Level Flags

This block holds two independent word queues for a serial controller. The transmit queue is filled by the host and drained by the serial engine. The receive queue is filled by the engine and drained by the host. Each queue holds 16 entries of up to 32 bits. Each one reports its occupancy as a 5-bit count, has full and empty flags, and keeps sticky fault flags for a push that was refused and for a pop that was refused.

A shared entry-width setting zero-fills the unused upper byte lanes of every word at the moment it is pushed. A 3-byte word still takes a whole entry. Each queue has its own 4-bit threshold and its own flush input. The receive queue raises its interrupt line while its occupancy is strictly above the receive threshold. The transmit queue raises its interrupt line while it is empty. It also reports a low-water flag while its occupancy is at or below the transmit threshold.

Top module: `dual_word_fifo`

## Requirements
- R1: Each queue holds up to 16 entries and returns them in push order. Its count output equals the number of entries held (0 to 16) and updates on the clock edge that accepts the push or pop.
- R2: A queue's full flag is 1 exactly when its count is 16. Its empty flag is 1 exactly when its count is 0.
- R3: A push to a full queue is dropped, so the count and stored data are unchanged. The push sets that queue's overflow flag, which stays at 1 until reset or a flush of that queue.
- R4: A pop from an empty queue is ignored, and the count stays 0. The pop sets that queue's underflow flag, which stays at 1 until reset or a flush of that queue.
- R5: A flush empties its queue and clears both of its fault flags at the next edge. In that cycle the flush wins over any push or pop to the same queue.
- R6: Flushing one queue leaves the count and contents of the other queue unchanged.
- R7: The receive interrupt line is 1 exactly when the receive count is strictly greater than the 4-bit receive threshold.
- R8: The transmit low-water flag is 1 exactly when the transmit count is less than or equal to the 4-bit transmit threshold.
- R9: The transmit interrupt line is 1 exactly when the transmit queue is empty.
- R10: The entry-width setting is sampled at push time. Code 0 keeps bits 7:0, code 1 keeps bits 15:0, code 2 keeps bits 23:0 and code 3 keeps bits 31:0. The bits above the kept lanes are stored as zero, and each word takes one entry whatever the code.
- R11: A push and a pop in the same cycle on a queue that is neither full nor empty leave the count unchanged and keep the order.
- R12: After reset both counts are 0, both queues are empty and not full, all fault flags and the receive interrupt line are 0, and the transmit interrupt line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Entry width code (0 to 3 means 1 to 4 bytes) |
| cfg_tx_thr | input | 4 | Transmit low-water threshold |
| cfg_rx_thr | input | 4 | Receive level threshold |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| tx_push | input | 1 | Host writes a word to the transmit queue |
| tx_wdata | input | 32 | Word written to the transmit queue |
| tx_pop | input | 1 | Engine takes the head word of the transmit queue |
| tx_rdata | output | 32 | Head word of the transmit queue |
| tx_count | output | 5 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_low | output | 1 | Transmit occupancy at or below threshold |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| irq_tx | output | 1 | Transmit interrupt (queue empty) |
| rx_push | input | 1 | Engine writes a word to the receive queue |
| rx_wdata | input | 32 | Word written to the receive queue |
| rx_pop | input | 1 | Host takes the head word of the receive queue |
| rx_rdata | output | 32 | Head word of the receive queue |
| rx_count | output | 5 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| irq_rx | output | 1 | Receive interrupt (occupancy above threshold) |

## Verification
The hardest cases to reach are the ones where a flush meets a push in the same cycle on a full queue that already has its overflow flag set. Three things can then go wrong together: the flush can lose to the push, the count can be left at 1, or the sticky flag can survive. The stimulus fills the transmit queue to 16 with 16 pushes and forces an overflow with a 17th push. It checks that the flag holds for an idle cycle, and then drives the flush and a push in one cycle. The threshold edges are checked at the exact counts where the compare flips (5 against 6 for the receive queue, 3 against 4 for the transmit queue). The width lanes are checked by pushing all-ones words under each width code and popping them in order.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
    typedef enum logic [1:0] {
        EW_ONE   = 2'd0,
        EW_TWO   = 2'd1,
        EW_THREE = 2'd2,
        EW_FOUR  = 2'd3
    } ent_width_e;

    localparam int LANE_BITS = 8;
endpackage

// File: rtl/wfifo_lane_mask.sv
module wfifo_lane_mask #(
    parameter int DW   = 32,
    parameter int SELW = 2
) (
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout
);
    localparam int LB    = wfifo_pkg::LANE_BITS;
    localparam int LANES = DW / LB;

    // lane b survives when the width code covers it
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign dout[b*LB +: LB] = (int'(sel) >= b) ? din[b*LB +: LB] : '0;
    end
endmodule

// File: rtl/wfifo_level.sv
module wfifo_level #(
    parameter int CW    = 5,
    parameter int TW    = 4,
    parameter bit ABOVE = 1'b1
) (
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] thr,
    output logic          hit
);
    logic [CW-1:0] thr_ext;
    assign thr_ext = CW'(thr);

    if (ABOVE) begin : g_above
        assign hit = (count > thr_ext);
    end else begin : g_low
        assign hit = (count <= thr_ext);
    end
endmodule

// File: rtl/wfifo_core.sv
module wfifo_core #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [DW-1:0]            wdata,
    input  logic                     pop,
    output logic [DW-1:0]            rdata,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty,
    output logic                     ovf,
    output logic                     unf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } st_t;

    st_t st_d, st_q;
    logic do_push, do_pop, is_full, is_empty;
    logic [DW-1:0] mem [DEPTH];

    assign is_full  = (st_q.cnt == CNT_FULL);
    assign is_empty = (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        do_push = 1'b0;
        do_pop  = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            do_push = push && !is_full;
            do_pop  = pop && !is_empty;
            if (push && is_full)  st_d.ovf = 1'b1;
            if (pop && is_empty)  st_d.unf = 1'b1;
            if (do_push) st_d.wptr = (st_q.wptr == PTR_LAST) ? '0 : st_q.wptr + 1'b1;
            if (do_pop)  st_d.rptr = (st_q.rptr == PTR_LAST) ? '0 : st_q.rptr + 1'b1;
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= wdata;
    end

    assign rdata = mem[st_q.rptr];
    assign count = st_q.cnt;
    assign full  = is_full;
    assign empty = is_empty;
    assign ovf   = st_q.ovf;
    assign unf   = st_q.unf;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CNT_FULL) && ovf); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (count == '0) && unf); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !ovf && !unf); // R5
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf); // R3
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && !full && !empty) |=> $stable(count)); // R11
endmodule

// File: rtl/dual_word_fifo.sv
module dual_word_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int SELW  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SELW-1:0]        cfg_width,
    input  logic [TW-1:0]          cfg_tx_thr,
    input  logic [TW-1:0]          cfg_rx_thr,
    input  logic                   tx_flush,
    input  logic                   rx_flush,
    input  logic                   tx_push,
    input  logic [DW-1:0]          tx_wdata,
    input  logic                   tx_pop,
    output logic [DW-1:0]          tx_rdata,
    output logic [$clog2(DEPTH):0] tx_count,
    output logic                   tx_full,
    output logic                   tx_empty,
    output logic                   tx_low,
    output logic                   tx_ovf,
    output logic                   tx_unf,
    output logic                   irq_tx,
    input  logic                   rx_push,
    input  logic [DW-1:0]          rx_wdata,
    input  logic                   rx_pop,
    output logic [DW-1:0]          rx_rdata,
    output logic [$clog2(DEPTH):0] rx_count,
    output logic                   rx_full,
    output logic                   rx_empty,
    output logic                   rx_ovf,
    output logic                   rx_unf,
    output logic                   irq_rx
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [DW-1:0] tx_masked, rx_masked;

    wfifo_lane_mask #(.DW(DW), .SELW(SELW)) u_tx_mask (
        .sel(cfg_width), .din(tx_wdata), .dout(tx_masked));
    wfifo_lane_mask #(.DW(DW), .SELW(SELW)) u_rx_mask (
        .sel(cfg_width), .din(rx_wdata), .dout(rx_masked));

    wfifo_core #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(tx_masked), .pop(tx_pop), .rdata(tx_rdata),
        .count(tx_count), .full(tx_full), .empty(tx_empty),
        .ovf(tx_ovf), .unf(tx_unf));

    wfifo_core #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_masked), .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_count), .full(rx_full), .empty(rx_empty),
        .ovf(rx_ovf), .unf(rx_unf));

    wfifo_level #(.CW(CW), .TW(TW), .ABOVE(1'b0)) u_tx_lvl (
        .count(tx_count), .thr(cfg_tx_thr), .hit(tx_low));
    wfifo_level #(.CW(CW), .TW(TW), .ABOVE(1'b1)) u_rx_lvl (
        .count(rx_count), .thr(cfg_rx_thr), .hit(irq_rx));

    assign irq_tx = tx_empty;

    AST_FLUSH_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !tx_flush && !tx_push && !tx_pop) |=> $stable(tx_count)); // R6
endmodule

// File: tb/tb_dual_word_fifo.sv
`timescale 1ns/1ps
module tb_dual_word_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd3;
    logic [3:0]  cfg_tx_thr = 4'd3, cfg_rx_thr = 4'd5;
    logic tx_flush = 0, rx_flush = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic [4:0]  tx_count, rx_count;
    logic tx_full, tx_empty, tx_low, tx_ovf, tx_unf, irq_tx;
    logic rx_full, rx_empty, rx_ovf, rx_unf, irq_rx;
    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    dual_word_fifo dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .cfg_tx_thr(cfg_tx_thr), .cfg_rx_thr(cfg_rx_thr),
        .tx_flush(tx_flush), .rx_flush(rx_flush),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .tx_low(tx_low),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf), .irq_tx(irq_tx),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf), .irq_rx(irq_rx));

    // {push, pop, wdata[31:0], exp_count[4:0], exp_head[31:0]}
    localparam logic [70:0] VEC [8] = '{
        {1'b1, 1'b0, 32'h0000_00A1, 5'd1, 32'h0000_00A1},
        {1'b1, 1'b0, 32'h0000_00B2, 5'd2, 32'h0000_00A1},
        {1'b1, 1'b0, 32'h0000_00C3, 5'd3, 32'h0000_00A1},
        {1'b1, 1'b1, 32'h0000_00D4, 5'd3, 32'h0000_00B2},
        {1'b0, 1'b1, 32'h0000_0000, 5'd2, 32'h0000_00C3},
        {1'b0, 1'b1, 32'h0000_0000, 5'd1, 32'h0000_00D4},
        {1'b1, 1'b0, 32'h0000_00E5, 5'd2, 32'h0000_00D4},
        {1'b0, 1'b1, 32'h0000_0000, 5'd1, 32'h0000_00E5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // inputs are set one time unit after an edge, sampled one unit after the next
    task automatic tick();
        @(posedge clk);
        #1;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_flush = 0; rx_flush = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R12 reset state
        chk("R12", 32'(tx_count), 0);
        chk("R12", 32'(rx_count), 0);
        chk("R12", {tx_empty, rx_empty, tx_full, rx_full}, 32'b1100);
        chk("R12", {tx_ovf, tx_unf, rx_ovf, rx_unf, irq_rx}, 0);
        chk("R12", {irq_tx, tx_low}, 32'b11);

        // R1 / R11 vector walk on the transmit queue
        for (int i = 0; i < 8; i++) begin
            tx_push  = VEC[i][70];
            tx_pop   = VEC[i][69];
            tx_wdata = VEC[i][68:37];
            tick();
            chk("R1", 32'(tx_count), 32'(VEC[i][36:32]));
            chk("R11", tx_rdata, VEC[i][31:0]);
        end

        tx_flush = 1; tick();
        chk("R5", 32'(tx_count), 0);

        // fill to 16, watching the low-water edge
        for (int i = 0; i < 16; i++) begin
            tx_push = 1; tx_wdata = 32'h100 + 32'(i);
            tick();
            if (i == 2) chk("R8", 32'(tx_low), 1);
            if (i == 3) chk("R8", 32'(tx_low), 0);
        end
        chk("R1", 32'(tx_count), 16);
        chk("R2", {tx_full, tx_empty}, 32'b10);
        chk("R9", 32'(irq_tx), 0);
        tx_push = 1; tx_wdata = 32'hDEAD; tick();
        chk("R3", 32'(tx_count), 16);
        chk("R3", 32'(tx_ovf), 1);
        chk("R3", tx_rdata, 32'h100);
        tick();
        chk("R3", 32'(tx_ovf), 1);
        // flush beats a same-cycle push
        tx_flush = 1; tx_push = 1; tx_wdata = 32'hBEEF; tick();
        chk("R5", 32'(tx_count), 0);
        chk("R5", 32'(tx_ovf), 0);
        chk("R2", {tx_full, tx_empty}, 32'b01);
        chk("R9", 32'(irq_tx), 1);

        // R10 width lanes on the receive queue, R7 threshold edge
        for (int w = 0; w < 4; w++) begin
            cfg_width = 2'(w); rx_push = 1; rx_wdata = 32'hFFFF_FFFF; tick();
        end
        cfg_width = 2'd3;
        rx_push = 1; rx_wdata = 32'h1234_5678; tick();
        chk("R7", 32'(irq_rx), 0);
        rx_push = 1; rx_wdata = 32'h0000_00AB; tick();
        chk("R7", 32'(irq_rx), 1);
        chk("R10", rx_rdata, 32'h0000_00FF);
        rx_pop = 1; tick();
        chk("R10", rx_rdata, 32'h0000_FFFF);
        rx_pop = 1; tick();
        chk("R10", rx_rdata, 32'h00FF_FFFF);
        rx_pop = 1; tick();
        chk("R10", rx_rdata, 32'hFFFF_FFFF);
        rx_pop = 1; tick();
        chk("R10", rx_rdata, 32'h1234_5678);
        chk("R7", 32'(irq_rx), 0);

        // R6 flush independence
        tx_push = 1; tx_wdata = 32'h55; tick();
        tx_push = 1; tx_wdata = 32'h66; tick();
        rx_flush = 1; tick();
        chk("R6", 32'(rx_count), 0);
        chk("R6", 32'(tx_count), 2);
        chk("R6", tx_rdata, 32'h55);

        // R4 underflow
        rx_pop = 1; tick();
        chk("R4", 32'(rx_count), 0);
        chk("R4", 32'(rx_unf), 1);
        rx_push = 1; rx_pop = 1; rx_wdata = 32'h77; tick();
        chk("R4", 32'(rx_count), 1);
        chk("R4", {rx_unf, tx_unf}, 32'b10);
        chk("R4", rx_rdata, 32'h77);

        finish_run();
    end
endmodule